// File: doc/BRIEF.md
# Geometric-Curve Brightness PWM Generator

This block turns a 5-bit brightness level into an on/off gate for an LED current sink. The on-time of each gate period follows a geometric curve. Every step up in level multiplies the on-time by 1/0.9. Equal steps in level therefore look like equal steps in brightness to the eye. The top level (31) keeps the gate on for the whole period, and level 0 keeps it off.

The period is 2^CNT_W counter positions, 1024 with the default CNT_W of 10. The counter is clocked in one of two ways:
- **Internal source:** the counter advances one position every INT_DIV core clocks. With the default divider and a 102.4 MHz core clock this gives a 20 kHz gate.
- **External source:** the counter advances SYNC_DIV-th of a period on each rising edge of an asynchronous sync clock. One gate period therefore lasts SYNC_DIV sync cycles, so a 1 MHz sync clock gives a 31.25 kHz gate.

A new level is taken only when a period begins, so a period already under way is never cut short or stretched.

Top module: `geo_dim_pwm`

## Requirements
- R1: On the internal source, for each level c from 1 to 30, the gate stays high for D(c) = round(1024 × 0.9^(31−c)) counter positions per period, and never fewer than 1. The gate then stays low for the rest of the period. Each high run begins at the start of the period.
- R2: Level 0 keeps the gate low for whole periods.
- R3: Level 31 keeps the gate high for whole periods, with no low cycle.
- R4: With src_sel = 0 (internal source), the counter advances one position every INT_DIV clocks. One gate period therefore lasts 1024 × INT_DIV clocks. Neither the counter nor the gate changes between advances.
- R5: With src_sel = 1 (external source), each synchronized rising sync edge moves the counter by 1024 / SYNC_DIV positions. One gate period therefore lasts SYNC_DIV sync cycles. The gate is high for ceil(D(c) / (1024/SYNC_DIV)) sync cycles, and for the whole period at level 31.
- R6: A level change takes effect only at the next period start. A period in progress completes with its old on-time, whether the new level is higher or lower.
- R7: While reset is asserted the gate is low. After reset is released, the first period starts on the first counter advance and uses the level present at that time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| level_code | input | CODE_W | Brightness level, 0 = off, 31 = full |
| src_sel | input | 1 | Period time base: 0 internal divider, 1 external sync |
| sync_clk | input | 1 | External sync clock, asynchronous to clk |
| sink_gate | output | 1 | PWM gate for the current sink |

## Verification
The bench builds the block with INT_DIV = 2, keeping CNT_W = 10 and SYNC_DIV = 32. With these values a full internal period lasts only 2048 clocks, so every level from 1 to 30 can be swept and its on-time measured against the rounded geometric table within the run. The divider of 2 still exercises the internal divider's wrap. SYNC_DIV = 32 with a 20-clock sync period makes external periods 640 clocks long. Coarse on-time quantization on that path, and level changes in mid-run in both directions, are therefore cheap to observe.

// File: rtl/geo_dim_pkg.sv
package geo_dim_pkg;

  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } tick_src_e;

  // On-time in counter positions for one level; fixed point with 16 fraction bits.
  function automatic int unsigned on_ticks(int unsigned code, int unsigned code_w,
                                           int unsigned cnt_w);
    int unsigned acc;
    int unsigned res;
    int unsigned top;
    top = (1 << code_w) - 1;
    if (code == 0) return 0;
    acc = (1 << cnt_w) << 16;
    for (int unsigned i = 0; i < top - code; i++) begin
      acc = (acc * 9 + 5) / 10;
    end
    res = (acc + 32768) >> 16;
    if (res == 0) res = 1;
    return res;
  endfunction

endpackage

// File: rtl/geo_dim_rom.sv
module geo_dim_rom #(
  parameter int CODE_W = 5,
  parameter int CNT_W  = 10
) (
  input  logic [CODE_W-1:0] code,
  output logic [CNT_W:0]    on_len
);
  import geo_dim_pkg::*;

  localparam int LEVELS = 1 << CODE_W;

  logic [CNT_W:0] table_w [LEVELS];

  for (genvar c = 0; c < LEVELS; c++) begin : g_lvl
    assign table_w[c] = (CNT_W+1)'(on_ticks(c, CODE_W, CNT_W));
  end

  assign on_len = table_w[code];

endmodule

// File: rtl/geo_dim_tick.sv
module geo_dim_tick #(
  parameter int CNT_W    = 10,
  parameter int INT_DIV  = 5,
  parameter int SYNC_DIV = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  geo_dim_pkg::tick_src_e src,
  input  logic                   sync_in,
  output logic                   tick,
  output logic [CNT_W:0]         step
);
  import geo_dim_pkg::*;

  localparam int PERIOD   = 1 << CNT_W;
  localparam int EXT_STEP = PERIOD / SYNC_DIV;
  localparam int DIV_W    = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(INT_DIV - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic             int_tick;
  logic [2:0]       sync_q, sync_d;
  logic             ext_edge;

  always_comb begin
    int_tick = (div_q == DIV_LAST);
    div_d    = int_tick ? '0 : div_q + DIV_W'(1);
    sync_d   = {sync_q[1:0], sync_in};
    ext_edge = sync_q[1] & ~sync_q[2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sync_q <= '0;
    end else begin
      div_q  <= div_d;
      sync_q <= sync_d;
    end
  end

  assign tick = (src == SRC_EXT) ? ext_edge : int_tick;
  assign step = (src == SRC_EXT) ? (CNT_W+1)'(EXT_STEP) : (CNT_W+1)'(1);

endmodule

// File: rtl/geo_dim_core.sv
module geo_dim_core #(
  parameter int CNT_W = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic [CNT_W:0] step,
  input  logic [CNT_W:0] on_new,
  output logic           gate,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W:0] on_cur
);
  localparam logic [CNT_W:0] PERIOD = (CNT_W+1)'(1) << CNT_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   on_q, on_d;
  logic             gate_q, gate_d;
  logic [CNT_W:0]   sum;
  logic             wrap;

  always_comb begin
    sum    = {1'b0, cnt_q} + step;
    wrap   = (sum >= PERIOD);
    cnt_d  = wrap ? '0 : sum[CNT_W-1:0];
    on_d   = wrap ? on_new : on_q;
    gate_d = ({1'b0, cnt_d} < on_d);
  end

  // Counter starts at its last position so the first advance opens a period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '1;
      on_q   <= '0;
      gate_q <= 1'b0;
    end else if (tick) begin
      cnt_q  <= cnt_d;
      on_q   <= on_d;
      gate_q <= gate_d;
    end
  end

  assign gate   = gate_q;
  assign cnt    = cnt_q;
  assign on_cur = on_q;

endmodule

// File: rtl/geo_dim_pwm.sv
module geo_dim_pwm #(
  parameter int CODE_W   = 5,
  parameter int CNT_W    = 10,
  parameter int INT_DIV  = 5,
  parameter int SYNC_DIV = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] level_code,
  input  logic              src_sel,
  input  logic              sync_clk,
  output logic              sink_gate
);
  import geo_dim_pkg::*;

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic             tick_w;
  logic [CNT_W:0]   step_w;
  logic [CNT_W:0]   on_new_w;
  logic [CNT_W:0]   duty_w;
  logic [CNT_W-1:0] cnt_w;
  tick_src_e        src_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign src_w = tick_src_e'(src_sel);

  geo_dim_tick #(.CNT_W(CNT_W), .INT_DIV(INT_DIV), .SYNC_DIV(SYNC_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .src    (src_w),
    .sync_in(sync_clk),
    .tick   (tick_w),
    .step   (step_w)
  );

  geo_dim_rom #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_rom (
    .code  (level_code),
    .on_len(on_new_w)
  );

  geo_dim_core #(.CNT_W(CNT_W)) u_core (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (tick_w),
    .step  (step_w),
    .on_new(on_new_w),
    .gate  (sink_gate),
    .cnt   (cnt_w),
    .on_cur(duty_w)
  );

endmodule

// File: rtl/geo_dim_pwm_chk.sv
module geo_dim_pwm_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             tick_w,
  input logic [CNT_W-1:0] cnt_w,
  input logic [CNT_W:0]   duty_w,
  input logic             sink_gate
);
  localparam logic [CNT_W:0] FULL = (CNT_W+1)'(1) << CNT_W;

  // R1
  high_in_window_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sink_gate |-> ({1'b0, cnt_w} < duty_w));

  // R2
  zero_level_off_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (duty_w == '0) |-> !sink_gate);

  // R3
  full_level_on_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (duty_w == FULL) |-> sink_gate);

  // R4
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !tick_w |=> ($stable(cnt_w) && $stable(sink_gate)));

  // R6
  latch_at_start_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(duty_w) |-> (cnt_w == '0));

  // R7
  reset_low_chk: assert property (@(posedge clk)
    !rst_sync_n |-> !sink_gate);

endmodule

bind geo_dim_pwm geo_dim_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .tick_w    (tick_w),
  .cnt_w     (cnt_w),
  .duty_w    (duty_w),
  .sink_gate (sink_gate)
);

// File: tb/geo_dim_pwm_test.sv
`timescale 1ns/1ps
module geo_dim_pwm_test;
  localparam int CODE_W   = 5;
  localparam int CNT_W    = 10;
  localparam int INT_DIV  = 2;
  localparam int SYNC_DIV = 32;
  localparam int PER_INT  = 1024 * INT_DIV;
  localparam int SYNC_CYC = 20;
  localparam int PER_EXT  = SYNC_DIV * SYNC_CYC;
  localparam int EXT_STEP = 1024 / SYNC_DIV;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [CODE_W-1:0] level_code;
  logic              src_sel;
  logic              sync_clk = 1'b0;
  logic              sink_gate;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  string tag_q[$];

  geo_dim_pwm #(.CODE_W(CODE_W), .CNT_W(CNT_W), .INT_DIV(INT_DIV), .SYNC_DIV(SYNC_DIV)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .level_code(level_code),
    .src_sel   (src_sel),
    .sync_clk  (sync_clk),
    .sink_gate (sink_gate)
  );

  always #5 clk = ~clk;
  initial begin
    #3;
    forever #100 sync_clk = ~sync_clk;
  end

  function automatic int exp_on(int c);
    real r;
    int d;
    if (c == 0) return 0;
    r = 1024.0;
    for (int k = 0; k < 31 - c; k++) r = r * 0.9;
    d = $rtoi(r + 0.5);
    if (d < 1) d = 1;
    return d;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push_run(input int n, input string req);
    exp_q.push_back(n);
    tag_q.push_back(req);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic wait_rise();
    bit p;
    @(negedge clk);
    p = sink_gate;
    forever begin
      @(negedge clk);
      if (!p && sink_gate) break;
      p = sink_gate;
    end
  endtask

  task automatic count_high(input int window, output int n);
    n = 0;
    for (int i = 0; i < window; i++) begin
      @(negedge clk);
      if (sink_gate) n++;
    end
  endtask

  task automatic measure_period(output int n);
    bit p;
    wait_rise();
    n = 0;
    p = 1'b1;
    forever begin
      @(negedge clk);
      n++;
      if (!p && sink_gate) break;
      p = sink_gate;
    end
  endtask

  // Monitor: measures each high run and compares with the oldest expectation.
  initial begin
    int run;
    int e;
    string t;
    run = 0;
    forever begin
      @(negedge clk);
      if (sink_gate === 1'b1) run++;
      else begin
        if (run > 0 && exp_q.size() != 0) begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(run == e, t, run, e);
        end
        run = 0;
      end
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int hit;
    rst_n = 1'b0;
    level_code = 5'd31;
    src_sel = 1'b0;
    repeat (5) @(negedge clk);
    // R7: low during reset
    check(sink_gate == 1'b0, "R7 reset low", sink_gate, 0);
    rst_n = 1'b1;
    hit = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (sink_gate && hit == 0) hit = i + 1;
    end
    // R7: first period opens on first advance with present level
    check(hit != 0, "R7 first period", hit, 1);

    // R3: full level
    repeat (PER_INT) @(negedge clk);
    count_high(PER_INT, n);
    check(n == PER_INT, "R3 full on", n, PER_INT);

    // R4: internal period length
    level_code = 5'd10;
    repeat (2 * PER_INT) @(negedge clk);
    measure_period(n);
    check(n == PER_INT, "R4 internal period", n, PER_INT);

    // R1: sweep of all intermediate levels
    for (int c = 1; c <= 30; c++) begin
      level_code = CODE_W'(c);
      repeat (PER_INT) @(negedge clk);
      push_run(exp_on(c) * INT_DIV, $sformatf("R1 level %0d", c));
      drain();
    end

    // R6: shrink in mid-run, then grow in mid-run
    level_code = 5'd20;
    repeat (2 * PER_INT) @(negedge clk);
    wait_rise();
    repeat (10) @(negedge clk);
    level_code = 5'd5;
    push_run(exp_on(20) * INT_DIV, "R6 old on-time kept (shrink)");
    drain();
    repeat (PER_INT) @(negedge clk);
    push_run(exp_on(5) * INT_DIV, "R6 new on-time next period");
    drain();
    wait_rise();
    repeat (10) @(negedge clk);
    level_code = 5'd25;
    push_run(exp_on(5) * INT_DIV, "R6 old on-time kept (grow)");
    drain();

    // R2: level 0
    level_code = 5'd0;
    repeat (2 * PER_INT) @(negedge clk);
    count_high(PER_INT, n);
    check(n == 0, "R2 zero off", n, 0);

    // R7: reset in mid-run
    level_code = 5'd31;
    repeat (2 * PER_INT) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(sink_gate == 1'b0, "R7 reset mid-run", sink_gate, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    hit = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (sink_gate && hit == 0) hit = i + 1;
    end
    check(hit != 0, "R7 restart", hit, 1);

    // R5: external sync source
    src_sel = 1'b1;
    level_code = 5'd10;
    repeat (3 * PER_EXT) @(negedge clk);
    measure_period(n);
    check(n == PER_EXT, "R5 external period", n, PER_EXT);
    push_run(((exp_on(10) + EXT_STEP - 1) / EXT_STEP) * SYNC_CYC, "R5 level 10 external");
    drain();
    level_code = 5'd1;
    repeat (2 * PER_EXT) @(negedge clk);
    push_run(((exp_on(1) + EXT_STEP - 1) / EXT_STEP) * SYNC_CYC, "R5 level 1 external");
    drain();
    level_code = 5'd31;
    repeat (2 * PER_EXT) @(negedge clk);
    count_high(PER_EXT, n);
    check(n == PER_EXT, "R5 level 31 external", n, PER_EXT);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule